// File: doc/BRIEF.md
# I2C Master Controller with Register Interface

This block is a bus master for a two-wire serial bus, run by a hardware state machine and controlled through a small set of byte-wide registers, in the way a microcontroller peripheral is. Software sets the enable bit, the bit-rate code and the read length in the mode register. It then writes the slave address together with a direction bit, and that one write launches the whole transaction. The controller issues a start condition and shifts out the address byte. It then checks the slave's acknowledge. For a write it sends one byte from the transmit register. For a read it collects the programmed number of bytes into a receive FIFO, acknowledging each byte but the last. It always finishes with a stop condition.

The two bus lines are open-drain: the block only pulls a line low or lets it go. A pin-select input hands the pins to a neighbouring serial peripheral, and while that input is low both drivers stay off. Status flags report completion and both kinds of missing acknowledge. The flags clear on a write of one and drive a maskable interrupt.

Engine states, in the order a transaction visits them: `ST_IDLE` → `ST_START` (on launch) → `ST_ADDR` (8 bits) → `ST_ADDR_ACK`. From `ST_ADDR_ACK` the engine goes to `ST_STOP` on a NACK, to `ST_READ` when the direction bit is 1, or to `ST_WRITE` otherwise. `ST_WRITE` (8 bits) → `ST_WRITE_ACK` → `ST_STOP`. `ST_READ` (8 bits) → `ST_READ_ACK`, which returns to `ST_READ` until the last byte and then goes to `ST_STOP`. `ST_STOP` → `ST_IDLE`. Every bit slot is four quarter-periods long: two with SCL low, then two with SCL released. SDA is updated in the second low quarter and sampled at the end of the first high quarter.

Top module: `i2c_master_ctl`

## Requirements
- R1: After reset every register reads 0, both line drivers are off and `irq` is low. Offsets: 0 mode, 1 slave address, 2 transmit data, 3 receive data, 4 status, 5 interrupt enable.
- R2: A write to offset 1 while mode bit 7 (enable) is 0 starts nothing. Status bit 0 (busy) stays 0 and neither line is ever driven.
- R3: The SCL period is 16 << rate core-clock cycles, where rate is mode bits 6:5. Codes 0 to 3 therefore give 16, 32, 64 and 128 cycles.
- R4: In a write, offset 1 holds the 7-bit address in bits 7:1 and a 0 in bit 0. The block sends that address byte MSB first, then the offset-2 byte, then a stop. Afterwards status reads 0x02, meaning done (bit 1) with no error.
- R5: In a read (offset 1 bit 0 = 1) the block receives mode[4:0] + 1 bytes. It drives an acknowledge after every byte but the last, sends a not-acknowledge after the last, and then issues a stop.
- R6: If the address byte is not acknowledged, the block sets status bit 2, transfers no data byte, and still issues a stop and sets done.
- R7: If the written data byte is not acknowledged, the block sets status bit 3 and done.
- R8: Each transaction has exactly one start (SDA falls while SCL is high) and one stop (SDA rises while SCL is high). At all other times SDA changes only while SCL is low.
- R9: While `pin_sel` is 0, `sda_oe` and `scl_oe` stay 0, even during a transaction.
- R10: Status bits 1 to 3 clear on a write of 1 to that bit; a write of 0 leaves the bit unchanged. `irq` is high when offset 5 bit 0 is 1 and any of status bits 1 to 3 is set.
- R11: A write to offset 1 while busy is ignored. The stored address is unchanged and no second start occurs.
- R12: Reads of offset 3 return received bytes in arrival order. Status bit 4 is 1 while the FIFO holds data, and a read of an empty FIFO returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO at offset 3) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| pin_sel | input | 1 | 1 = this block owns the bus pins |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| irq | output | 1 | Interrupt request |

## Verification
Register effects show up at the first clock edge after the strobe. Status is read back a full cycle later, and combinational read data is sampled one time unit after the bench drives the read on a falling edge. Bus results are due one core cycle after each quarter-period tick, because the line drivers are registered. The bench therefore never predicts line timing to the cycle. It decodes the lines with a bus model that samples on falling core-clock edges: on SCL rises it samples, on SCL falls it drives, and it measures the SCL period as the distance between two consecutive rising edges inside the address byte. Checks on status and FIFO wait until the busy bit has dropped, by polling status.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_STOP
    } eng_state_t;

    localparam logic [2:0] OFS_MODE  = 3'd0;
    localparam logic [2:0] OFS_SLAVE = 3'd1;
    localparam logic [2:0] OFS_TX    = 3'd2;
    localparam logic [2:0] OFS_RX    = 3'd3;
    localparam logic [2:0] OFS_STAT  = 3'd4;
    localparam logic [2:0] OFS_IE    = 3'd5;

    localparam int MODE_EN_BIT = 7;
    localparam int CNT_W       = 5;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int BASE_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int QLOG = BASE_LOG2 - 2;
    localparam int CW   = BASE_LOG2 + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // quarter period = (2^BASE_LOG2 / 4) << rate cycles
    assign lim  = CW'((32'd1 << (QLOG + 32'(rate))) - 32'd1);
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2cm_rxfifo.sv
module i2cm_rxfifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop, full;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [6:0]       addr7,
    input  logic             rw,
    input  logic [7:0]       tx_byte,
    input  logic [CNT_W-1:0] rd_cnt,
    input  logic             tick,
    input  logic             sda_in,
    output logic             busy,
    output logic             scl_lo,
    output logic             sda_lo,
    output logic             rx_push,
    output logic [7:0]       rx_byte,
    output logic             done_p,
    output logic             anack_p,
    output logic             dnack_p
);
    eng_state_t       state_q, state_d;
    logic [1:0]       phase_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q;
    logic             rw_q, samp_q;
    logic [CNT_W-1:0] cnt_q, byte_q;
    logic             adv, last, byte_state;

    assign adv        = tick && (phase_q == 2'd3);
    assign last       = (byte_q == cnt_q);
    assign busy       = (state_q != ST_IDLE);
    assign byte_state = (state_q == ST_ADDR) || (state_q == ST_WRITE) ||
                        (state_q == ST_READ);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go) state_d = ST_START;
            ST_START:     if (adv) state_d = ST_ADDR;
            ST_ADDR:      if (adv && bit_q == 3'd0) state_d = ST_ADDR_ACK;
            ST_ADDR_ACK:  if (adv) state_d = samp_q ? ST_STOP :
                                             (rw_q ? ST_READ : ST_WRITE);
            ST_WRITE:     if (adv && bit_q == 3'd0) state_d = ST_WRITE_ACK;
            ST_WRITE_ACK: if (adv) state_d = ST_STOP;
            ST_READ:      if (adv && bit_q == 3'd0) state_d = ST_READ_ACK;
            ST_READ_ACK:  if (adv) state_d = last ? ST_STOP : ST_READ;
            ST_STOP:      if (adv) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: phase, bit and byte counters, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= 3'd7;
            sh_q    <= '0;
            rw_q    <= 1'b0;
            samp_q  <= 1'b1;
            cnt_q   <= '0;
            byte_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            phase_q <= '0;
            bit_q   <= 3'd7;
            if (go) begin
                sh_q   <= {addr7, rw};
                rw_q   <= rw;
                cnt_q  <= rd_cnt;
                byte_q <= '0;
            end
        end else if (tick) begin
            phase_q <= phase_q + 1'b1;
            if (phase_q == 2'd2) begin
                samp_q <= sda_in;
                if (state_q == ST_READ) sh_q <= {sh_q[6:0], sda_in};
            end
            if (phase_q == 2'd3) begin
                bit_q <= byte_state ? bit_q - 1'b1 : 3'd7;
                if (state_q == ST_ADDR || state_q == ST_WRITE)
                    sh_q <= {sh_q[6:0], 1'b0};
                if (state_q == ST_ADDR_ACK) sh_q <= tx_byte;
                if (state_q == ST_READ_ACK) byte_q <= byte_q + 1'b1;
            end
        end
    end

    assign rx_push = adv && (state_q == ST_READ) && (bit_q == 3'd0);
    assign rx_byte = sh_q;
    assign done_p  = adv && (state_q == ST_STOP);
    assign anack_p = adv && (state_q == ST_ADDR_ACK) && samp_q;
    assign dnack_p = adv && (state_q == ST_WRITE_ACK) && samp_q;

    // line drivers (registered)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_lo <= 1'b0;
            sda_lo <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    scl_lo <= 1'b0;
                    sda_lo <= 1'b0;
                end
                ST_START: begin
                    scl_lo <= 1'b0;
                    sda_lo <= phase_q[1];
                end
                ST_STOP: begin
                    scl_lo <= ~phase_q[1];
                    if (phase_q == 2'd1) sda_lo <= 1'b1;
                end
                ST_ADDR, ST_WRITE: begin
                    scl_lo <= ~phase_q[1];
                    if (phase_q == 2'd1) sda_lo <= ~sh_q[7];
                end
                ST_READ_ACK: begin
                    scl_lo <= ~phase_q[1];
                    if (phase_q == 2'd1) sda_lo <= ~last;
                end
                default: begin
                    scl_lo <= ~phase_q[1];
                    if (phase_q == 2'd1) sda_lo <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_master_ctl.sv
module i2c_master_ctl
    import i2cm_pkg::*;
#(
    parameter int BASE_LOG2 = 4,
    parameter int RX_DEPTH  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       pin_sel,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       irq
);
    logic [7:0] mode_q, slv_q, tx_q;
    logic       ie_q, st_done, st_anack, st_dnack;
    logic       busy, go, tick, scl_lo, sda_lo;
    logic       rx_push, rx_pop, rx_empty;
    logic [7:0] rx_byte, rx_dout;
    logic       done_p, anack_p, dnack_p;
    logic       wr_stat;

    assign go      = reg_wr && (reg_addr == OFS_SLAVE) && mode_q[MODE_EN_BIT] && !busy;
    assign rx_pop  = reg_rd && (reg_addr == OFS_RX);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            slv_q  <= '0;
            tx_q   <= '0;
            ie_q   <= 1'b0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                OFS_MODE:  mode_q <= reg_wdata;
                OFS_SLAVE: if (!busy) slv_q <= reg_wdata;
                OFS_TX:    tx_q <= reg_wdata;
                OFS_IE:    ie_q <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    // status flags: set wins over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_done  <= 1'b0;
            st_anack <= 1'b0;
            st_dnack <= 1'b0;
        end else begin
            st_done  <= done_p  || (st_done  && !(wr_stat && reg_wdata[1]));
            st_anack <= anack_p || (st_anack && !(wr_stat && reg_wdata[2]));
            st_dnack <= dnack_p || (st_dnack && !(wr_stat && reg_wdata[3]));
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_MODE:  reg_rdata = mode_q;
            OFS_SLAVE: reg_rdata = slv_q;
            OFS_TX:    reg_rdata = tx_q;
            OFS_RX:    reg_rdata = rx_dout;
            OFS_STAT:  reg_rdata = {3'b000, !rx_empty, st_dnack, st_anack, st_done, busy};
            OFS_IE:    reg_rdata = {7'b0, ie_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq    = ie_q && (st_done || st_anack || st_dnack);
    assign scl_oe = pin_sel && scl_lo;
    assign sda_oe = pin_sel && sda_lo;

    i2cm_qtick #(.BASE_LOG2(BASE_LOG2)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .rate (mode_q[6:5]),
        .tick (tick)
    );

    i2cm_engine u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .addr7  (reg_wdata[7:1]),
        .rw     (reg_wdata[0]),
        .tx_byte(tx_q),
        .rd_cnt (mode_q[CNT_W-1:0]),
        .tick   (tick),
        .sda_in (sda_in),
        .busy   (busy),
        .scl_lo (scl_lo),
        .sda_lo (sda_lo),
        .rx_push(rx_push),
        .rx_byte(rx_byte),
        .done_p (done_p),
        .anack_p(anack_p),
        .dnack_p(dnack_p)
    );

    i2cm_rxfifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_push),
        .din  (rx_byte),
        .pop  (rx_pop),
        .dout (rx_dout),
        .empty(rx_empty)
    );
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pin_sel,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       st_done,
    input logic       st_anack,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic       en
);
    // R9
    pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sel |-> (!scl_oe && !sda_oe));

    // R2
    launch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == OFS_SLAVE && en));

    // R4
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> st_done);

    // R6
    anack_keeps_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_anack) |-> busy);

    // R8
    idle_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (!scl_oe && !sda_oe));

    // R8
    start_inside_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> busy);
endmodule

bind i2c_master_ctl i2cm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_sel (pin_sel),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .busy    (busy),
    .st_done (st_done),
    .st_anack(st_anack),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .en      (mode_q[7])
);

// File: tb/i2c_master_ctl_tb.sv
module i2c_master_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pin_sel = 1'b1;
    logic       scl_oe, sda_oe, irq;
    logic       s_lo = 1'b0;
    wire        sda_line = ~(sda_oe | s_lo);
    wire        scl_line = ~scl_oe;

    int nvec = 0, nerr = 0;
    int cyc = 0;
    localparam logic [6:0] SLV = 7'h5A;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_master_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_sel(pin_sel), .sda_in(sda_line), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .irq(irq)
    );

    function automatic logic [7:0] exp_rd(input int i);
        return 8'h3C + 8'(i * 29);
    endfunction

    // bus slave model, sampled on falling core-clock edges
    logic ps = 1'b1, pc = 1'b1;
    bit   s_active = 0, s_skip = 0, s_addr_ph = 0, s_tx = 0, s_macked = 0;
    bit   force_dnack = 0, any_oe = 0;
    int   k = 0, s_idx = 0, starts = 0, stops = 0, macks = 0, mnacks = 0;
    int   wr_cnt = 0, t0 = 0, period = 0;
    logic [7:0] s_sh = '0, s_txb = '0, got_addr = '0, got_wr = '0;

    always @(negedge clk) begin
        if (sda_oe || scl_oe) any_oe = 1;
        if (pc && scl_line && ps && !sda_line) begin
            starts++; s_active = 1; s_skip = 1; k = 0; s_addr_ph = 1;
            s_tx = 0; s_lo = 1'b0;
        end else if (pc && scl_line && !ps && sda_line) begin
            stops++; s_active = 0; s_lo = 1'b0;
        end else if (s_active && !pc && scl_line) begin
            if (s_addr_ph && k == 0) t0 = cyc;
            if (s_addr_ph && k == 1) period = cyc - t0;
            if (k < 8 && !s_tx) s_sh = {s_sh[6:0], sda_line};
            if (k == 8 && s_tx) begin
                s_macked = !sda_line;
                if (!sda_line) macks++; else mnacks++;
            end
        end else if (s_active && pc && !scl_line) begin
            if (s_skip) s_skip = 0;
            else begin
                k++;
                if (k == 8) begin
                    if (!s_tx) begin
                        if (s_addr_ph) begin
                            got_addr = s_sh;
                            if (s_sh[7:1] == SLV) s_lo = 1'b1;
                            else begin s_lo = 1'b0; s_active = 0; end
                        end else begin
                            got_wr = s_sh; wr_cnt++; s_lo = !force_dnack;
                        end
                    end else s_lo = 1'b0;
                end else if (k == 9) begin
                    k = 0;
                    if (s_addr_ph) begin
                        s_addr_ph = 0; s_tx = got_addr[0]; s_idx = 0;
                    end else if (s_tx) s_idx++;
                    if (s_tx && (s_idx == 0 || s_macked)) begin
                        s_txb = exp_rd(s_idx); s_lo = !s_txb[7];
                    end else s_lo = 1'b0;
                end else if (s_tx) s_lo = !s_txb[7-k];
            end
        end
        ps = sda_line; pc = scl_line;
    end

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd4, s);
            if (!s[0]) return;
        end
        chk("watchdog-idle", 1, 0);
    endtask

    task automatic clr_bus();
        starts = 0; stops = 0; macks = 0; mnacks = 0; wr_cnt = 0;
        period = 0; any_oe = 0; got_addr = '0; got_wr = '0;
    endtask

    task automatic xfer(input int rate, input int cnt, input logic [6:0] a,
                        input logic dir, input logic [7:0] data);
        wr(3'd4, 8'h0E);
        wr(3'd0, {1'b1, 2'(rate), 5'(cnt)});
        wr(3'd2, data);
        clr_bus();
        wr(3'd1, {a, dir});
        wait_idle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d); chk("R1 reg", d, 0);
        end
        chk("R1 pins", {scl_oe, sda_oe}, 0);
        chk("R1 irq", irq, 0);

        // R2 launch while disabled
        clr_bus();
        wr(3'd1, {SLV, 1'b0});
        repeat (100) @(negedge clk);
        rd(3'd4, d); chk("R2 busy", d[0], 0);
        chk("R2 no drive", any_oe, 0);

        // R3 R4 R8 writes over every rate
        for (int r = 0; r < 4; r++) begin
            logic [7:0] dat = 8'h96 ^ 8'(r * 51);
            xfer(r, 0, SLV, 1'b0, dat);
            chk("R3 scl period", period, 16 << r);
            chk("R4 addr byte", got_addr, {SLV, 1'b0});
            chk("R4 data byte", got_wr, dat);
            rd(3'd4, d); chk("R4 status", d, 8'h02);
            chk("R8 starts", starts, 1);
            chk("R8 stops", stops, 1);
        end

        // R5 R12 reads over counts
        for (int c = 0; c < 18; c++) begin
            int n = (c == 16) ? 31 : (c == 17 ? 2 : c);
            int r = (c == 17) ? 1 : 0;
            xfer(r, n, SLV, 1'b1, 8'h00);
            chk("R5 acks", macks, n);
            chk("R5 last nack", mnacks, 1);
            chk("R8 stops", stops, 1);
            rd(3'd4, d); chk("R12 not empty", d, 8'h12);
            for (int i = 0; i <= n; i++) begin
                rd(3'd3, d); chk("R12 fifo data", d, exp_rd(i));
            end
            rd(3'd4, d); chk("R12 drained", d[4], 0);
        end
        rd(3'd3, d); chk("R12 empty read", d, 0);

        // R6 address nack
        xfer(0, 3, 7'h11, 1'b1, 8'h00);
        rd(3'd4, d); chk("R6 status", d, 8'h06);
        chk("R6 no data", macks + mnacks + wr_cnt, 0);
        chk("R6 stop", stops, 1);

        // R7 data nack
        force_dnack = 1;
        xfer(0, 0, SLV, 1'b0, 8'hC3);
        force_dnack = 0;
        rd(3'd4, d); chk("R7 status", d, 8'h0A);

        // R9 pins not owned
        pin_sel = 1'b0;
        xfer(0, 0, SLV, 1'b0, 8'h44);
        pin_sel = 1'b1;
        chk("R9 no drive", any_oe, 0);
        chk("R9 no start", starts, 0);

        // R10 W1C and interrupt mask
        rd(3'd4, d); chk("R10 before", d, 8'h06);
        wr(3'd4, 8'h02);
        rd(3'd4, d); chk("R10 partial clear", d, 8'h04);
        chk("R10 irq masked", irq, 0);
        wr(3'd5, 8'h01);
        @(negedge clk); chk("R10 irq on", irq, 1);
        wr(3'd4, 8'h04);
        @(negedge clk); chk("R10 irq off", irq, 0);
        xfer(0, 0, SLV, 1'b0, 8'h5F);
        wr(3'd4, 8'h00);
        chk("R10 irq done", irq, 1);
        wr(3'd4, 8'h0E);
        @(negedge clk); chk("R10 irq cleared", irq, 0);
        wr(3'd5, 8'h00);

        // R11 write while busy ignored
        wr(3'd0, 8'h80);
        clr_bus();
        wr(3'd1, {SLV, 1'b0});
        repeat (20) @(negedge clk);
        wr(3'd1, 8'hE7);
        wait_idle();
        repeat (4) @(negedge clk);
        rd(3'd1, d); chk("R11 addr kept", d, {SLV, 1'b0});
        chk("R11 one start", starts, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule